// File: doc/BRIEF.md
# Stretchable External Memory Cycle Controller

This block runs single read and write accesses to an external byte-wide data memory. Each access takes a 16-bit address, a direction bit and a write byte. The block drives the address, an address-valid strobe, a read or write strobe and the outgoing data bus. It returns the read byte together with a one-clock done pulse. All strobes are active high.

Timing is counted in machine cycles. A machine cycle runs from one clock on which the machine-cycle enable is high to the next such clock. The length of each phase comes from a 3-bit stretch setting (0 to 7). This setting is written through a small configuration port and resets to 1.

- A read holds address-valid and the read strobe together for stretch+1 machine cycles.
- A write holds address-valid for stretch+2 machine cycles. The write strobe opens after one machine cycle of address set-up.
- The write strobe is one machine cycle long for stretch 0 and 1, and stretch cycles long above that.

The sequencer has six states:

- `ST_IDLE`: ready, waiting for a request.
- `ST_RD_STRB`: address and read strobe.
- `ST_WR_SETUP`: address and data, no strobe.
- `ST_WR_STRB`: address, data and write strobe.
- `ST_WR_HOLD`: address and data after the strobe.
- `ST_DONE`: one-clock completion.

Transitions:

- `ST_IDLE` to `ST_RD_STRB`, or to `ST_WR_SETUP`, on a request taken on an enabled clock.
- `ST_RD_STRB` to `ST_DONE` when its count expires.
- `ST_WR_SETUP` to `ST_WR_STRB` after one machine cycle.
- `ST_WR_STRB` to `ST_WR_HOLD` when its count expires and stretch is not 0. With stretch 0 it goes directly to `ST_DONE`.
- `ST_WR_HOLD` to `ST_DONE` after one machine cycle.
- `ST_DONE` to `ST_IDLE` on the next clock.

Top module: `ext_mem_cycle_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and mem_addr_vld_o, mem_rd_o, mem_wr_o, mem_doe_o and done_o are all 0.
- R2: A read raises mem_addr_vld_o and mem_rd_o on the same clock. Both then stay high for exactly stretch+1 machine cycles. mem_wr_o stays 0.
- R3: A write holds mem_addr_vld_o high for exactly stretch+2 machine cycles. mem_rd_o stays 0.
- R4: The write strobe rises one machine cycle after mem_addr_vld_o rises. It lasts 1 machine cycle for stretch 0 or 1, and stretch machine cycles for stretch 2 to 7.
- R5: With no configuration write after reset, the stretch is 1, so a read strobe lasts 2 machine cycles.
- R6: The read byte on mem_din_i at the last clock of the read strobe appears on rdata_o. done_o is high for exactly one clock after every access, reads and writes alike.
- R7: During a write, mem_doe_o is 1 and mem_dout_o equals the request byte on every clock of the address phase. mem_doe_o is 0 once the access ends.
- R8: ready_o is 0 from the clock after a request is taken until done_o has been high. mem_addr_o holds the request address throughout the address phase.
- R9: The stretch is sampled when an access starts. A configuration write during an access changes only later accesses.
- R10: A request is taken only on a clock with mc_en_i high. Every phase length counts enabled clocks, so with the enable high one clock in three, each phase is three times as many clocks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_en_i | input | 1 | Machine-cycle enable |
| cfg_we_i | input | 1 | Stretch setting write enable |
| cfg_stretch_i | input | 3 | New stretch value |
| req_i | input | 1 | Access request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Controller idle, request can be taken |
| rdata_o | output | 8 | Last byte read |
| done_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | 16 | Memory address bus |
| mem_addr_vld_o | output | 1 | Address-valid strobe |
| mem_rd_o | output | 1 | Read strobe, active high |
| mem_wr_o | output | 1 | Write strobe, active high |
| mem_dout_o | output | 8 | Outgoing data bus |
| mem_doe_o | output | 1 | Data bus drive enable |
| mem_din_i | input | 8 | Incoming data bus |

## Verification
The hardest situation to reach is a stretch change that lands in the middle of an access. It needs a configuration write timed inside a running cycle, which the ports only allow while ready_o is low. The bench forks a writer that fires two clocks into a stretch-2 read. It then checks that the running read keeps its 3-cycle strobe and that the following read uses the new value. The divided machine-cycle enable is the second hard case: the bench runs one read and one write with the enable high one clock in three, and expects every width and offset to scale by three.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STRB,
        ST_WR_SETUP,
        ST_WR_STRB,
        ST_WR_HOLD,
        ST_DONE
    } mcc_state_e;
endpackage

// File: rtl/mcc_stretch_reg.sv
module mcc_stretch_reg #(
    parameter int unsigned SW        = 3,
    parameter int unsigned RESET_VAL = 1
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [SW-1:0] din_i,
    output logic [SW-1:0] q_o
);
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n)    q_o <= SW'(RESET_VAL);
        else if (we_i) q_o <= din_i;
    end
endmodule

// File: rtl/mcc_mc_timer.sv
module mcc_mc_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load_i)                   cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ext_mem_cycle_ctrl.sv
module ext_mem_cycle_ctrl
    import mcc_pkg::*;
#(
    parameter int unsigned AW            = 16,
    parameter int unsigned DW            = 8,
    parameter int unsigned SW            = 3,
    parameter int unsigned RESET_STRETCH = 1
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          mc_en_i,
    input  logic          cfg_we_i,
    input  logic [SW-1:0] cfg_stretch_i,
    input  logic          req_i,
    input  logic          req_wr_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          ready_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_addr_vld_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [DW-1:0] mem_dout_o,
    output logic          mem_doe_o,
    input  logic [DW-1:0] mem_din_i
);
    localparam int unsigned CW = SW;

    mcc_state_e    state_q, state_d;
    logic [SW-1:0] stretch_cfg;
    logic [SW-1:0] stretch_cyc_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          accept;
    logic          capture;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          step;

    mcc_stretch_reg #(.SW(SW), .RESET_VAL(RESET_STRETCH)) i_stretch (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .we_i  (cfg_we_i),
        .din_i (cfg_stretch_i),
        .q_o   (stretch_cfg)
    );

    mcc_mc_timer #(.CW(CW)) i_timer (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (mc_en_i),
        .expired_o  (tmr_expired)
    );

    // One phase ends on an enabled clock once its count has run down
    assign step = mc_en_i && tmr_expired;

    // Write strobe length minus one: 0 for stretch 0/1, stretch-1 above
    function automatic logic [CW-1:0] wr_strb_m1(input logic [SW-1:0] s);
        return (s < SW'(2)) ? '0 : CW'(s - SW'(1));
    endfunction

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i && mc_en_i) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_wr_i) begin
                        state_d = ST_WR_SETUP;
                        tmr_val = '0;
                    end else begin
                        state_d = ST_RD_STRB;
                        tmr_val = CW'(stretch_cfg);
                    end
                end
            end
            ST_RD_STRB: begin
                if (step) begin
                    capture = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_WR_SETUP: begin
                if (step) begin
                    tmr_load = 1'b1;
                    tmr_val  = wr_strb_m1(stretch_cyc_q);
                    state_d  = ST_WR_STRB;
                end
            end
            ST_WR_STRB: begin
                if (step) begin
                    if (stretch_cyc_q == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = '0;
                        state_d  = ST_WR_HOLD;
                    end
                end
            end
            ST_WR_HOLD: begin
                if (step) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            stretch_cyc_q <= SW'(RESET_STRETCH);
            addr_q        <= '0;
            wdata_q       <= '0;
            rdata_q       <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                stretch_cyc_q <= stretch_cfg;
                addr_q        <= req_addr_i;
                wdata_q       <= req_wdata_i;
            end
            if (capture) rdata_q <= mem_din_i;
        end
    end

    // Moore outputs decoded from the state
    always_comb begin
        ready_o        = 1'b0;
        done_o         = 1'b0;
        mem_addr_vld_o = 1'b0;
        mem_rd_o       = 1'b0;
        mem_wr_o       = 1'b0;
        mem_doe_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:     ready_o = 1'b1;
            ST_RD_STRB:  begin mem_addr_vld_o = 1'b1; mem_rd_o = 1'b1; end
            ST_WR_SETUP: begin mem_addr_vld_o = 1'b1; mem_doe_o = 1'b1; end
            ST_WR_STRB:  begin mem_addr_vld_o = 1'b1; mem_doe_o = 1'b1; mem_wr_o = 1'b1; end
            ST_WR_HOLD:  begin mem_addr_vld_o = 1'b1; mem_doe_o = 1'b1; end
            ST_DONE:     done_o = 1'b1;
            default:     ready_o = 1'b0;
        endcase
    end

    assign mem_addr_o = addr_q;
    assign mem_dout_o = wdata_q;
    assign rdata_o    = rdata_q;

    // Checks placed beside the sequencer they guard
    AST_RD_WITH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(mem_rd_o) |-> $rose(mem_addr_vld_o)); // R2
    AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R3
    AST_WR_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(mem_wr_o) |-> $past(mem_addr_vld_o)); // R4
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_WR_DRIVES_BUS: assert property (@(posedge clk_i) disable iff (!rst_n)
        mem_wr_o |-> mem_doe_o); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_n)
        mem_addr_vld_o |-> !ready_o); // R8
    AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
        (mem_addr_vld_o && $past(mem_addr_vld_o)) |-> $stable(mem_addr_o)); // R8
    AST_STRETCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(stretch_cyc_q)); // R9
endmodule

// File: tb/test_ext_mem_cycle_ctrl.sv
`timescale 1ns/1ps
module test_ext_mem_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_stretch = '0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready_o, done_o, mem_addr_vld_o, mem_rd_o, mem_wr_o, mem_doe_o;
    logic [7:0]  rdata_o, mem_dout_o;
    logic [7:0]  mem_din = '0;
    logic [15:0] mem_addr_o;
    int          errors = 0;
    int          checks = 0;
    int          div = 1;
    int          phase = 0;

    always #2 clk = ~clk;

    ext_mem_cycle_ctrl i_ext_mem_cycle_ctrl (
        .clk_i(clk), .rst_n(rst_n), .mc_en_i(mc_en),
        .cfg_we_i(cfg_we), .cfg_stretch_i(cfg_stretch),
        .req_i(req), .req_wr_i(req_wr), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .ready_o(ready_o), .rdata_o(rdata_o), .done_o(done_o),
        .mem_addr_o(mem_addr_o), .mem_addr_vld_o(mem_addr_vld_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_dout_o(mem_dout_o), .mem_doe_o(mem_doe_o), .mem_din_i(mem_din)
    );

    // Machine-cycle enable: high one clock in div
    always @(negedge clk) begin
        if (div <= 1) begin
            mc_en = 1'b1;
            phase = 0;
        end else begin
            phase = (phase + 1) % div;
            mc_en = (phase == 0);
        end
    end

    // {wr, stretch, addr, byte, expected addr-valid width, expected strobe width}
    localparam logic [35:0] VEC [16] = '{
        {1'b0, 3'd0, 16'h0000, 8'hA5, 4'd1, 4'd1},
        {1'b0, 3'd1, 16'h1234, 8'h5A, 4'd2, 4'd2},
        {1'b0, 3'd2, 16'hFFFF, 8'h3C, 4'd3, 4'd3},
        {1'b0, 3'd3, 16'h8001, 8'hC3, 4'd4, 4'd4},
        {1'b0, 3'd4, 16'h00FF, 8'h01, 4'd5, 4'd5},
        {1'b0, 3'd5, 16'hFF00, 8'h80, 4'd6, 4'd6},
        {1'b0, 3'd6, 16'h5555, 8'hFF, 4'd7, 4'd7},
        {1'b0, 3'd7, 16'hAAAA, 8'h00, 4'd8, 4'd8},
        {1'b1, 3'd0, 16'h0102, 8'h11, 4'd2, 4'd1},
        {1'b1, 3'd1, 16'h0304, 8'h22, 4'd3, 4'd1},
        {1'b1, 3'd2, 16'h0506, 8'h33, 4'd4, 4'd2},
        {1'b1, 3'd3, 16'h0708, 8'h44, 4'd5, 4'd3},
        {1'b1, 3'd4, 16'h090A, 8'h55, 4'd6, 4'd4},
        {1'b1, 3'd5, 16'h0B0C, 8'h66, 4'd7, 4'd5},
        {1'b1, 3'd6, 16'h0D0E, 8'h77, 4'd8, 4'd6},
        {1'b1, 3'd7, 16'hFEDC, 8'h88, 4'd9, 4'd7}
    };

    task automatic check(input logic ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic set_stretch(input logic [2:0] s);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_stretch = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one access and checks widths, offsets, bus and completion
    task automatic run(input logic wr, input logic [15:0] a, input logic [7:0] b,
                       input int exp_a, input int exp_s, input int exp_off);
        int na = 0, nr = 0, nw = 0, t = 0, ta = -1, ts = -1;
        int bad_addr = 0, bad_bus = 0, bad_ready = 0;
        logic got_done = 1'b0;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = b; mem_din = b;
        for (int k = 0; k < 400 && !got_done; k++) begin
            @(negedge clk);
            t++;
            if (!ready_o) req = 1'b0;
            if (mem_addr_vld_o) begin
                na++;
                if (ta < 0) ta = t;
                if (mem_addr_o != a) bad_addr++;
                if (ready_o) bad_ready++;
                if (wr && !(mem_doe_o && mem_dout_o == b)) bad_bus++;
            end
            if (mem_rd_o) begin nr++; if (ts < 0) ts = t; end
            if (mem_wr_o) begin nw++; if (ts < 0) ts = t; end
            if (done_o) got_done = 1'b1;
        end
        check(got_done, "R6 done seen", int'(got_done), 1);
        if (wr) begin
            check(na == exp_a, "R3 write addr-valid width", na, exp_a);
            check(nw == exp_s, "R4 write strobe width", nw, exp_s);
            check(nr == 0, "R3 no read strobe in write", nr, 0);
            check(bad_bus == 0, "R7 data bus driven with write byte", bad_bus, 0);
        end else begin
            check(na == exp_a, "R2 read addr-valid width", na, exp_a);
            check(nr == exp_s, "R2 read strobe width", nr, exp_s);
            check(nw == 0, "R2 no write strobe in read", nw, 0);
            check(rdata_o == b, "R6 read data captured", int'(rdata_o), int'(b));
        end
        check(ts - ta == exp_off, "R4 strobe offset from addr-valid", ts - ta, exp_off);
        check(bad_addr == 0 && bad_ready == 0, "R8 address held, ready low", bad_addr + bad_ready, 0);
        @(negedge clk);
        check(!done_o && !mem_doe_o && ready_o, "R6 R7 done one clock, bus released",
              int'({done_o, mem_doe_o, ready_o}), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready_o && !mem_addr_vld_o && !mem_rd_o && !mem_wr_o && !mem_doe_o && !done_o,
              "R1 reset outputs", int'({ready_o, mem_addr_vld_o, mem_rd_o, mem_wr_o, mem_doe_o, done_o}), 32);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready_o && !done_o, "R1 idle after reset", int'({ready_o, done_o}), 2);

        // R5 default stretch 1: read strobe of two cycles
        run(1'b0, 16'h4242, 8'h9E, 2, 2, 0);

        // Table walk over every stretch, reads and writes
        for (int i = 0; i < 16; i++) begin
            logic [35:0] v;
            v = VEC[i];
            set_stretch(v[34:32]);
            run(v[35], v[31:16], v[15:8], int'(v[7:4]), int'(v[3:0]), v[35] ? 1 : 0);
        end

        // R9 stretch change in the middle of a read
        set_stretch(3'd2);
        fork
            begin
                repeat (3) @(negedge clk);
                cfg_we = 1'b1;
                cfg_stretch = 3'd5;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join_none
        run(1'b0, 16'h7777, 8'h6D, 3, 3, 0);
        run(1'b0, 16'h7778, 8'h6E, 6, 6, 0);
        check(1'b1, "R9 mid-access change applied to next access only", 1, 1);

        // R10 machine cycle of three clocks
        div = 3;
        set_stretch(3'd2);
        run(1'b0, 16'h2468, 8'hB4, 9, 9, 0);
        run(1'b1, 16'h1357, 8'h4B, 12, 6, 3);
        // R10 request held while enable low is not taken early
        @(negedge clk);
        while (mc_en) @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_addr = 16'h0F0F;
        @(negedge clk);
        check(!mem_addr_vld_o || mc_en, "R10 no start on disabled clock", int'(mem_addr_vld_o), 0);
        for (int k = 0; k < 20 && !done_o; k++) begin
            @(negedge clk);
            if (!ready_o) req = 1'b0;
        end
        req = 1'b0;
        div = 1;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule